// File: doc/BRIEF.md
# Byte-wide synchronous serial shift engine

This block moves one byte at a time across a three-wire synchronous serial link: a serial clock, a data-out line and a data-in line. The host sets a small configuration before a transfer: whether bits go most or least significant first, where the serial clock comes from, and which edge launches data. The host then pulses `start` with a byte on `tx_byte`. While `busy` is high the engine shifts that byte out and gathers eight incoming bits. It then latches them into `rx_byte` and pulses `done` for one cycle.

With an internal clock the engine divides the system clock by a power of two chosen by a 3-bit code and drives the serial clock pin. Code 111 selects an external clock instead. In that case the pin is released, the incoming clock passes through a two-flop synchronizer, and the engine shifts on the edges it detects there. The external clock must be slower than one quarter of the system clock. A low-speed mode replaces the system clock with a slow timebase, given as a one-cycle tick input. In that mode only code 000 is legal, and it divides the slow timebase by eight.

The configuration is captured when a transfer is accepted. Changes to it during a transfer take effect only on the next byte.

Top module: `sio_engine`

## Requirements
- R1: With `cfg_msb_first` = 1 the transmitted stream is bit 7 down to bit 0 and the first received bit lands in `rx_byte[7]`. With 0 the transmitted stream is bit 0 up to bit 7 and the first received bit lands in `rx_byte[0]`.
- R2: With `slow_mode` = 0, internal codes 000, 001, 010, 011, 100, 101 and 110 give a serial bit period of 512, 64, 32, 16, 8, 4 and 2 system clock cycles. That is the time between successive sampling edges on `sclk_o`.
- R3: Code 111 leaves the clock pin undriven (`sclk_oe` = 0) and shifts on the edges of `sclk_i`. When the accepted code is internal, `sclk_oe` = 1.
- R4: With `cfg_edge_sel` = 0, data is launched on falling serial-clock edges and sampled on rising ones, and the idle clock level is high. With 1, launch is on rising edges, sampling on falling edges, and the idle level is low. This applies to both clock sources.
- R5: With `slow_mode` = 1, code 000 gives a bit period of 8 `slow_tick` pulses. A start request with codes 001 to 110 is refused: `busy` stays 0 and no `done` follows.
- R6: An accepted `start` raises `busy` in the next cycle. In the cycle after the eighth sampling edge, `busy` is 0, `done` is 1 for exactly one cycle, and `rx_byte` holds the received byte.
- R7: The first transmit bit appears on `sdo` in the cycle after the start is accepted, before any clock edge. After the transfer, `sdo` keeps showing the last bit sent.
- R8: Changes to bit order, clock code or edge select while `busy` = 1, and further `start` pulses while `busy` = 1, do not affect the byte in progress.
- R9: After reset `busy` = 0, `done` = 0, `rx_byte` = 0 and `sdo` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | Select the slow timebase |
| slow_tick | input | 1 | One-cycle pulse at the slow timebase rate |
| cfg_msb_first | input | 1 | Bit order: 1 = MSB first |
| cfg_clk_sel | input | 3 | Clock code; 111 = external clock |
| cfg_edge_sel | input | 1 | Launch/sample edge pair select |
| start | input | 1 | Request a transfer |
| tx_byte | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last received byte |
| sclk_i | input | 1 | External serial clock in |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Clock pin drive enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench uses the default 8-bit byte and 8-bit half-period counter. With these, every internal clock code up to the slowest 512-cycle bit fits in a short run, so all seven codes are swept against both bit orders and both edge choices. The bench acts as a serial peer that launches and samples on the edges it sees, which checks the exact bit period, the edge roles, the bit order in both directions and where `done` lands. Runs with the external clock, with the slow timebase and with a refused code, plus one transfer disturbed by configuration changes and a second start, cover the remaining modes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITCNT_W = $clog2(BYTE_W);
  localparam int unsigned HALF_W   = 8;
  localparam int unsigned TOP_EXP  = 8;
  localparam int unsigned SLOW_EXP = 2;
  localparam logic [2:0]  SEL_EXT  = 3'b111;

  typedef struct packed {
    logic       msb_first;
    logic [2:0] sel;
    logic       edge_sel;
    logic       slow;
  } sio_cfg_t;

  // Half serial period minus one, in counter advances.
  function automatic logic [HALF_W-1:0] half_limit(input sio_cfg_t c);
    int unsigned e;
    if (c.slow) e = SLOW_EXP;
    else if (c.sel == 3'd0) e = TOP_EXP;
    else e = 32'd6 - 32'(c.sel);
    return HALF_W'((32'd1 << e) - 32'd1);
  endfunction

  function automatic logic cfg_ok(input sio_cfg_t c);
    return !(c.slow && (c.sel != 3'd0) && (c.sel != SEL_EXT));
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          idle_lvl,
  input  logic [HW-1:0] lim,
  input  logic          use_tick,
  input  logic          tick,
  output logic          sclk,
  output logic          launch,
  output logic          sample
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          adv, flip;

  assign adv  = use_tick ? tick : 1'b1;
  assign flip = run && adv && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run) begin
      cnt_d = '0;
      lvl_d = idle_lvl;
    end else if (adv) begin
      if (cnt_q == lim) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign sclk   = lvl_q;
  assign launch = flip && (lvl_q == idle_lvl);
  assign sample = flip && (lvl_q != idle_lvl);

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));
  a_r4_rest_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(idle_lvl)));
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int unsigned W  = BYTE_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] tx,
  input  logic         msb,
  input  logic         launch,
  input  logic         sample,
  input  logic         sdi,
  output logic         sdo,
  output logic         last,
  output logic [W-1:0] rx_next
);
  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0] n_q, n_d;

  assign rx_next = msb ? {rx_q[W-2:0], sdi} : {sdi, rx_q[W-1:1]};
  assign last    = sample && (n_q == CW'(W-1));

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    n_d  = n_q;
    if (load) begin
      tx_d = tx;
      rx_d = '0;
      n_d  = '0;
    end else begin
      if (launch && (n_q != '0))
        tx_d = msb ? {tx_q[W-2:0], 1'b0} : {1'b0, tx_q[W-1:1]};
      if (sample) begin
        rx_d = rx_next;
        n_d  = n_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      n_q  <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      n_q  <= n_d;
    end
  end

  assign sdo = msb ? tx_q[W-1] : tx_q[0];

  a_r7_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !load) |=> $stable(sdo));
  a_r6_no_sample_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sample);
endmodule

// File: rtl/sio_engine.sv
module sio_engine
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_mode,
  input  logic              slow_tick,
  input  logic              cfg_msb_first,
  input  logic [2:0]        cfg_clk_sel,
  input  logic              cfg_edge_sel,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdo,
  input  logic              sdi
);
  logic              rs1_q, rs2_q, arst_n;
  sio_cfg_t          live_c, cfg_q, cfg_d;
  logic              busy_q, busy_d, done_q;
  logic [BYTE_W-1:0] rx_q, rx_d, rx_next;
  logic              accept, ext_run, int_run, last;
  logic              i_launch, i_sample, x_rise, x_fall;
  logic              launch, sample, idle_lvl;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign arst_n = rs2_q;

  assign live_c = '{msb_first: cfg_msb_first, sel: cfg_clk_sel,
                    edge_sel: cfg_edge_sel, slow: slow_mode};
  assign accept  = start && !busy_q && cfg_ok(live_c);
  assign ext_run = (cfg_q.sel == SEL_EXT);
  assign int_run = busy_q && !ext_run;
  assign idle_lvl = busy_q ? ~cfg_q.edge_sel : ~cfg_edge_sel;

  sio_clkgen #(.HW(HALF_W)) u_clk (
    .clk(clk), .rst_n(arst_n), .run(int_run), .idle_lvl(idle_lvl),
    .lim(half_limit(cfg_q)), .use_tick(cfg_q.slow), .tick(slow_tick),
    .sclk(sclk_o), .launch(i_launch), .sample(i_sample));

  sio_edge_sync u_sync (
    .clk(clk), .rst_n(arst_n), .pin(sclk_i), .rise(x_rise), .fall(x_fall));

  assign launch = busy_q && (ext_run ? (cfg_q.edge_sel ? x_rise : x_fall) : i_launch);
  assign sample = busy_q && (ext_run ? (cfg_q.edge_sel ? x_fall : x_rise) : i_sample);

  sio_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(arst_n), .load(accept), .tx(tx_byte),
    .msb(cfg_q.msb_first), .launch(launch), .sample(sample), .sdi(sdi),
    .sdo(sdo), .last(last), .rx_next(rx_next));

  always_comb begin
    cfg_d  = accept ? live_c : cfg_q;
    busy_d = busy_q;
    if (accept) busy_d = 1'b1;
    else if (last) busy_d = 1'b0;
    rx_d = last ? rx_next : rx_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      done_q <= last;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk_oe = busy_q ? !ext_run : (cfg_clk_sel != SEL_EXT);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |=> !done_q);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  a_r6_rx_on_done: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(rx_q) |-> done_q);
  a_r3_pin_released: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && ext_run) |-> !sclk_oe);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));
  a_r5_code_refused: assert property (@(posedge clk) disable iff (!arst_n)
    (start && !busy_q && slow_mode && cfg_clk_sel != 3'd0 && cfg_clk_sel != SEL_EXT)
      |=> !busy_q);
endmodule

// File: tb/sio_engine_test.sv
module sio_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mode = 1'b0, slow_tick = 1'b0;
  logic       cfg_msb_first = 1'b0, cfg_edge_sel = 1'b0;
  logic [2:0] cfg_clk_sel = 3'd0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       busy, done, sclk_o, sclk_oe, sdo;
  logic [7:0] rx_byte;
  logic       sclk_i = 1'b1, sdi = 1'b0;
  int         n_chk = 0, n_bad = 0, done_cnt = 0, tick_div = 0;

  always #4 clk = ~clk;

  sio_engine uut (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .slow_tick(slow_tick),
    .cfg_msb_first(cfg_msb_first), .cfg_clk_sel(cfg_clk_sel),
    .cfg_edge_sel(cfg_edge_sel), .start(start), .tx_byte(tx_byte),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi));

  always @(negedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    tick_div  <= (tick_div == 2) ? 0 : tick_div + 1;
    slow_tick <= (tick_div == 2);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] b, input int k, input logic msb);
    return msb ? b[7-k] : b[k];
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // internal clock transfer with the bench as serial peer
  task automatic run_int(input logic msb, input logic [2:0] sel, input logic edg,
                         input logic slow, input logic [7:0] txb,
                         input logic [7:0] slv, input bit perturb);
    logic il, prev;
    logic [7:0] got;
    int samples, cyc, last_t, exp_per, d0;
    bit per_ok, done_ok;
    il = ~edg;
    exp_per = slow ? 24 : (2 << ((sel == 3'd0) ? 8 : 6 - sel));
    @(negedge clk);
    cfg_msb_first = msb; cfg_clk_sel = sel; cfg_edge_sel = edg; slow_mode = slow;
    tx_byte = txb; sdi = bit_at(slv, 0, msb);
    @(negedge clk);
    check(sclk_o == il, "R4 idle level", sclk_o, il);
    check(sclk_oe == 1'b1, "R3 internal drives pin", sclk_oe, 1);
    d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    check(sdo == bit_at(txb, 0, msb), "R7 first bit before clock", sdo, bit_at(txb, 0, msb));
    if (perturb) begin
      cfg_msb_first = ~msb; cfg_clk_sel = 3'd7; cfg_edge_sel = ~edg;
      tx_byte = ~txb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    prev = sclk_o; samples = 0; cyc = 0; last_t = 0; got = 8'h00;
    per_ok = 1'b1; done_ok = 1'b1;
    while (samples < 8 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (sclk_o != prev) begin
        if (sclk_o == il) begin
          if (msb) got[7-samples] = sdo; else got[samples] = sdo;
          samples++;
          if (samples > 1 && (cyc - last_t) != exp_per) per_ok = 1'b0;
          last_t = cyc;
          if (samples == 8) done_ok = (done == 1'b1) && (busy == 1'b0);
          else if (busy != 1'b1 || done != 1'b0) done_ok = 1'b0;
        end else if (samples > 0) begin
          sdi = bit_at(slv, samples, msb);
        end
      end
      prev = sclk_o;
    end
    check(samples == 8, "R6 eight sampling edges", samples, 8);
    check(per_ok, slow ? "R5 slow bit period" : "R2 bit period", sel, exp_per);
    check(done_ok, "R6 done with eighth sample", done, 1);
    check(got == txb, "R1 R4 transmit stream", got, txb);
    @(negedge clk);
    check(done == 1'b0 && done_cnt == d0 + 1, "R6 single done pulse", done_cnt - d0, 1);
    check(rx_byte == slv, "R1 received byte", rx_byte, slv);
    check(sdo == bit_at(txb, 7, msb), "R7 last bit held", sdo, bit_at(txb, 7, msb));
    check(sclk_o == (perturb ? edg : il), "R4 clock back at rest", sclk_o, il);
    cfg_edge_sel = edg; cfg_msb_first = msb;
  endtask

  task automatic run_ext(input logic msb, input logic edg,
                         input logic [7:0] txb, input logic [7:0] slv);
    logic [7:0] got;
    int d0;
    @(negedge clk);
    slow_mode = 1'b0; cfg_clk_sel = 3'd7; cfg_msb_first = msb; cfg_edge_sel = edg;
    sclk_i = ~edg; tx_byte = txb; sdi = bit_at(slv, 0, msb);
    repeat (6) @(negedge clk);
    d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sclk_oe == 1'b0, "R3 pin released", sclk_oe, 0);
    check(sdo == bit_at(txb, 0, msb), "R7 first bit ext", sdo, bit_at(txb, 0, msb));
    got = 8'h00;
    for (int k = 0; k < 8; k++) begin
      repeat (8) @(negedge clk);
      sclk_i = edg;
      if (k > 0) sdi = bit_at(slv, k, msb);
      repeat (8) @(negedge clk);
      if (msb) got[7-k] = sdo; else got[k] = sdo;
      sclk_i = ~edg;
    end
    repeat (8) @(negedge clk);
    check(got == txb, "R3 R1 ext transmit stream", got, txb);
    check(rx_byte == slv, "R3 R4 ext received byte", rx_byte, slv);
    check(busy == 1'b0 && done_cnt == d0 + 1, "R6 ext completion", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0, "R9 reset flags", {busy, done}, 0);
    check(rx_byte == 8'h00, "R9 reset rx", rx_byte, 0);
    check(sdo == 1'b0, "R9 reset sdo", sdo, 0);

    for (int s = 0; s < 7; s++)
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 2; m++)
          run_int(m[0], s[2:0], e[0], 1'b0, 8'h96 ^ 8'(s * 37 + e * 5 + m),
                  8'h3C ^ 8'(s * 11 + e * 64 + m * 129), 1'b0);

    // R5 slow timebase, legal code
    run_int(1'b1, 3'd0, 1'b0, 1'b1, 8'hA5, 8'h5A, 1'b0);
    run_int(1'b0, 3'd0, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b0);

    // R5 refused codes in slow mode
    for (int s = 1; s < 7; s++) begin
      @(negedge clk);
      slow_mode = 1'b1; cfg_clk_sel = s[2:0]; cfg_edge_sel = 1'b0;
      d0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R5 refused code no busy", busy, 0);
      repeat (30) @(negedge clk);
      check(busy == 1'b0 && done_cnt == d0 && sclk_o == 1'b1,
            "R5 refused code no transfer", done_cnt - d0, 0);
    end

    // R8 disturbance during a transfer
    run_int(1'b1, 3'd4, 1'b0, 1'b0, 8'hC3, 8'h2D, 1'b1);
    run_int(1'b0, 3'd5, 1'b1, 1'b0, 8'h17, 8'hE8, 1'b1);

    // R3 external clock
    run_ext(1'b1, 1'b0, 8'hB4, 8'h4B);
    run_ext(1'b0, 1'b0, 8'h69, 8'hD2);
    run_ext(1'b1, 1'b1, 8'h0F, 8'hF1);
    run_ext(1'b0, 1'b1, 8'h8E, 8'h35);

    summary();
  end
endmodule